// File: doc/BRIEF.md
# Thirty-Two-Function Byte ALU

A purely combinational arithmetic-logic unit for an 8-bit datapath. A 5-bit function code picks one of thirty-two operations on two operand bytes, `a_i` and `b_i`, and an incoming carry bit. The block returns one result byte together with carry, zero, negative, overflow and divide-error flags in the same cycle.

The operations fall into several families:

- constants and pass-through;
- negation, increment and decrement;
- binary add and subtract, with and without the carry input;
- a signed-compare subtract;
- multiply, returning the high or the low half of the product;
- unsigned divide and remainder;
- shifts by up to seven places;
- nine-bit rotates through the carry;
- bitwise logic;
- packed-decimal add and subtract;
- divide and remainder by ten of the 16-bit value formed with `b_i` as the upper byte and `a_i` as the lower byte.

A sequencer drives the operands and function code from its register file and latches the result and flags at its own clock edge. The carry input lets multi-byte add, subtract and rotate chains be built one byte at a time.

Top module: `alu_byte32`

## Requirements
- R1: Function codes 0, 1 and 2 give 0x00, `a_i` and `b_i` respectively, with carry and overflow clear.
- R2: Code 5 gives the low byte of ({b_i,a_i} / 10), with carry set when the quotient exceeds 255. Code 6 gives ({b_i,a_i} mod 10), with carry clear.
- R3: Codes 3, 4, 7 and 8 give 0-a, 0-b, b+1 and b-1. On the subtracting forms, carry reports a borrow. On the add form, carry reports the carry out. Overflow reports signed overflow.
- R4: Codes 9, 10 and 11 give a+b, a-b and b-a and ignore `carry_i`. Carry is the carry out for the add and the borrow for the subtracts, and overflow is signed overflow.
- R5: Code 12 gives a-b. Its carry is set when a is less than b as two's-complement numbers, and its overflow is signed overflow of a-b.
- R6: Codes 13, 14 and 15 give a+b+carry_i, a-b-carry_i and b-a-carry_i, with carry, borrow and overflow set as in R4.
- R7: Codes 16 and 17 give the high and the low byte of the unsigned product a*b. For code 17, carry is set when the high byte is nonzero.
- R8: Codes 18 and 19 give the unsigned a/b and a mod b. When b is zero they give 0xFF and a respectively and raise `div_err_o`. No other code raises `div_err_o`.
- R9: Codes 20, 21 and 22 shift a left, arithmetically right and logically right by b[2:0] places. Carry is the last bit shifted out, or 0 for a zero shift, and `carry_i` is ignored.
- R10: Codes 23 and 24 rotate the nine-bit ring {carry_i, a} left or right by b[2:0] places. The result is the low eight ring bits and carry is the top ring bit.
- R11: Codes 25 to 29 give a AND b, a OR b, a XOR b, NOT(a AND b) and NOT b, with carry clear.
- R12: Codes 30 and 31 treat a and b as two packed decimal digits each (high nibble = tens) and give the decimal sum and the ten's-complement difference. Carry is the decimal carry or borrow out, and `carry_i` is ignored.
- R13: For every code, `zero_o` is set exactly when the result is 0x00 and `neg_o` equals result bit 7. `ovf_o` is clear for codes 0-2, 5, 6 and 16-31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand; low byte of the divide-by-ten dividend |
| b_i | input | 8 | Second operand; high byte of the divide-by-ten dividend; low 3 bits give the shift amount |
| op_i | input | 5 | Function code |
| carry_i | input | 1 | Carry or borrow into codes 13-15 and into the rotates |
| result_o | output | 8 | Result byte |
| carry_o | output | 1 | Carry, borrow, shifted-out bit, or decimal carry |
| zero_o | output | 1 | Result equals zero |
| neg_o | output | 1 | Result bit 7 |
| ovf_o | output | 1 | Signed overflow of arithmetic codes |
| div_err_o | output | 1 | Divide or remainder by zero |

## Verification
Several properties are checked continuously, whatever the operands:

- the quotient-times-divisor-plus-remainder identity for both dividers;
- conservation of set bits around the nine-bit rotate ring;
- valid decimal digits out of the packed-decimal path whenever the inputs are valid;
- confinement of the overflow and divide-error flags to their own function codes.

Other behaviour can only be shown by the bench's scenarios against known values. This covers the exact result bytes, the carry polarity of each subtract form, the signed-compare carry of code 12, the zero-amount shift, rotate round trips, and the fact that the carry input is ignored where it should be.

// File: rtl/alu_byte32_pkg.sv
package alu_byte32_pkg;

  typedef enum logic [4:0] {
    OP_ZERO, OP_PASS_A, OP_PASS_B, OP_NEG_A, OP_NEG_B, OP_DIV10, OP_MOD10, OP_INC_B,
    OP_DEC_B, OP_ADD, OP_SUB, OP_RSB, OP_CMP_SUB, OP_ADC, OP_SBC, OP_RSC,
    OP_MUL_HI, OP_MUL_LO, OP_DIV, OP_MOD, OP_SHL, OP_ASR, OP_LSR, OP_RLC,
    OP_RRC, OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOT_B, OP_BCD_ADD, OP_BCD_SUB
  } op_e;

  // codes that may report signed overflow
  function automatic logic is_arith(op_e op);
    case (op)
      OP_NEG_A, OP_NEG_B, OP_INC_B, OP_DEC_B, OP_ADD, OP_SUB, OP_RSB,
      OP_CMP_SUB, OP_ADC, OP_SBC, OP_RSC: is_arith = 1'b1;
      default:                            is_arith = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_byte32_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] NONE = '0;

  // returns {ovf, carry, result}
  function automatic logic [W+1:0] f_add(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    logic [W:0] s;
    logic       v;
    s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    v = ~(x[W-1] ^ y[W-1]) & (s[W-1] ^ x[W-1]);
    return {v, s};
  endfunction

  // returns {ovf, borrow, result}
  function automatic logic [W+1:0] f_sub(logic [W-1:0] x, logic [W-1:0] y, logic bi);
    logic [W:0] d;
    logic       v;
    d = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, bi};
    v = (x[W-1] ^ y[W-1]) & (d[W-1] ^ x[W-1]);
    return {v, d};
  endfunction

  logic [W+1:0] r;
  logic         slt;

  assign slt = $signed(a_i) < $signed(b_i);

  always_comb begin
    case (op_i)
      OP_PASS_A:  r = {2'b00, a_i};
      OP_PASS_B:  r = {2'b00, b_i};
      OP_NEG_A:   r = f_sub(NONE, a_i, 1'b0);
      OP_NEG_B:   r = f_sub(NONE, b_i, 1'b0);
      OP_INC_B:   r = f_add(b_i, ONE, 1'b0);
      OP_DEC_B:   r = f_sub(b_i, ONE, 1'b0);
      OP_ADD:     r = f_add(a_i, b_i, 1'b0);
      OP_SUB:     r = f_sub(a_i, b_i, 1'b0);
      OP_RSB:     r = f_sub(b_i, a_i, 1'b0);
      OP_ADC:     r = f_add(a_i, b_i, carry_i);
      OP_SBC:     r = f_sub(a_i, b_i, carry_i);
      OP_RSC:     r = f_sub(b_i, a_i, carry_i);
      OP_CMP_SUB: begin
        r    = f_sub(a_i, b_i, 1'b0);
        r[W] = slt;
      end
      default:    r = '0;
    endcase
  end

  assign res_o = r[W-1:0];
  assign c_o   = r[W];
  assign v_o   = r[W+1];

endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
  import alu_byte32_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         err_o
);

  localparam int           DW  = 2 * W;
  localparam logic [DW-1:0] TEN = DW'(10);

  logic [DW-1:0] prod, ba, q10, r10w;
  logic [W-1:0]  q, r, r10;
  logic          b_zero;

  assign prod   = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign b_zero = (b_i == '0);
  assign q      = b_zero ? '1 : a_i / b_i;
  assign r      = b_zero ? a_i : a_i % b_i;
  assign ba     = {b_i, a_i};
  assign q10    = ba / TEN;
  assign r10w   = ba % TEN;
  assign r10    = r10w[W-1:0];

  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    err_o = 1'b0;
    case (op_i)
      OP_DIV10:  begin res_o = q10[W-1:0]; c_o = |q10[DW-1:W]; end
      OP_MOD10:  res_o = r10;
      OP_MUL_HI: res_o = prod[DW-1:W];
      OP_MUL_LO: begin res_o = prod[W-1:0]; c_o = |prod[DW-1:W]; end
      OP_DIV:    begin res_o = q; err_o = b_zero; end
      OP_MOD:    begin res_o = r; err_o = b_zero; end
      default:   ;
    endcase
  end

  always_comb begin
    if (!b_zero)
      p_div_identity_r8: assert ({{W{1'b0}}, q} * {{W{1'b0}}, b_i} + {{W{1'b0}}, r} == {{W{1'b0}}, a_i} && r < b_i)
        else $error("divider identity broken");
    p_div10_identity_r2: assert (q10 * TEN + {{W{1'b0}}, r10} == ba && r10 < W'(10))
      else $error("divide-by-ten identity broken");
  end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_byte32_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);

  localparam int AW = $clog2(W);
  localparam int RW = W + 1;

  logic [AW-1:0]   amt;
  logic [W:0]      t_shl, t_asr, t_lsr;
  logic [RW-1:0]   ring, rot_l, rot_r;
  logic [2*RW-1:0] dbl, dbl_l, dbl_r;

  assign amt   = b_i[AW-1:0];
  assign t_shl = {1'b0, a_i} << amt;
  assign t_asr = $signed({a_i, 1'b0}) >>> amt;
  assign t_lsr = {a_i, 1'b0} >> amt;

  assign ring  = {carry_i, a_i};
  assign dbl   = {ring, ring};
  assign dbl_l = dbl << amt;
  assign dbl_r = dbl >> amt;
  assign rot_l = dbl_l[2*RW-1:RW];
  assign rot_r = dbl_r[RW-1:0];

  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    case (op_i)
      OP_SHL:  begin res_o = t_shl[W-1:0]; c_o = t_shl[W]; end
      OP_ASR:  begin res_o = t_asr[W:1];   c_o = t_asr[0]; end
      OP_LSR:  begin res_o = t_lsr[W:1];   c_o = t_lsr[0]; end
      OP_RLC:  begin res_o = rot_l[W-1:0]; c_o = rot_l[W]; end
      OP_RRC:  begin res_o = rot_r[W-1:0]; c_o = rot_r[W]; end
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NAND: res_o = ~(a_i & b_i);
      OP_NOT_B: res_o = ~b_i;
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_RLC || op_i == OP_RRC)
      p_ring_bits_kept_r10: assert ($countones({c_o, res_o}) == $countones({carry_i, a_i}))
        else $error("rotate lost or gained a bit");
  end

endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);

  localparam int ND = W / 4;

  logic [ND:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    logic [3:0] ad, bd, dig;
    logic [4:0] t_add, t_sub;
    logic       add_hi;
    assign ad     = a_i[4*i +: 4];
    assign bd     = b_i[4*i +: 4];
    assign t_add  = {1'b0, ad} + {1'b0, bd} + {4'b0, cy[i]};
    assign t_sub  = {1'b0, ad} - {1'b0, bd} - {4'b0, cy[i]};
    assign add_hi = t_add > 5'd9;
    assign dig    = sub_i ? (t_sub[4] ? t_sub[3:0] + 4'd10 : t_sub[3:0])
                          : (add_hi   ? t_add[3:0] + 4'd6  : t_add[3:0]);
    assign cy[i+1]          = sub_i ? t_sub[4] : add_hi;
    assign res_o[4*i +: 4]  = dig;
  end

  assign c_o = cy[ND];

  function automatic logic digits_ok(logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < ND; k++)
      if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    if (digits_ok(a_i) && digits_ok(b_i))
      p_bcd_digits_valid_r12: assert (digits_ok(res_o))
        else $error("decimal adjust produced a non-decimal digit");
  end

endmodule

// File: rtl/alu_byte32.sv
module alu_byte32
  import alu_byte32_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   op_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o,
  output logic         div_err_o
);

  op_e op;
  assign op = op_e'(op_i);

  logic [W-1:0] ar_res, md_res, bo_res, bcd_res;
  logic         ar_c, ar_v, md_c, md_err, bo_c, bcd_c;

  alu_arith #(.W(W)) u_arith (
    .op_i(op), .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .res_o(ar_res), .c_o(ar_c), .v_o(ar_v)
  );

  alu_muldiv #(.W(W)) u_muldiv (
    .op_i(op), .a_i(a_i), .b_i(b_i),
    .res_o(md_res), .c_o(md_c), .err_o(md_err)
  );

  alu_bitops #(.W(W)) u_bitops (
    .op_i(op), .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .res_o(bo_res), .c_o(bo_c)
  );

  alu_bcd #(.W(W)) u_bcd (
    .a_i(a_i), .b_i(b_i), .sub_i(op == OP_BCD_SUB),
    .res_o(bcd_res), .c_o(bcd_c)
  );

  always_comb begin
    ovf_o     = 1'b0;
    div_err_o = 1'b0;
    case (op)
      OP_DIV10, OP_MOD10, OP_MUL_HI, OP_MUL_LO, OP_DIV, OP_MOD: begin
        result_o  = md_res;
        carry_o   = md_c;
        div_err_o = md_err;
      end
      OP_SHL, OP_ASR, OP_LSR, OP_RLC, OP_RRC,
      OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOT_B: begin
        result_o = bo_res;
        carry_o  = bo_c;
      end
      OP_BCD_ADD, OP_BCD_SUB: begin
        result_o = bcd_res;
        carry_o  = bcd_c;
      end
      default: begin
        result_o = ar_res;
        carry_o  = ar_c;
        ovf_o    = ar_v;
      end
    endcase
  end

  assign zero_o = ~|result_o;
  assign neg_o  = result_o[W-1];

  always_comb begin
    if (ovf_o)
      p_ovf_scope_r13: assert (is_arith(op)) else $error("overflow on non-arithmetic code");
    if (div_err_o)
      p_div_err_scope_r8: assert (op == OP_DIV || op == OP_MOD) else $error("divide error on wrong code");
  end

endmodule

// File: tb/sim_alu_byte32.sv
`timescale 1ns/1ps
module sim_alu_byte32;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a, b, res;
  logic [4:0] op;
  logic       cin, c, z, n, v, e;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  alu_byte32 u0 (
    .a_i(a), .b_i(b), .op_i(op), .carry_i(cin),
    .result_o(res), .carry_o(c), .zero_o(z), .neg_o(n), .ovf_o(v), .div_err_o(e)
  );

  // {op, a, b, cin, result, carry, ovf, div_err}
  localparam int NV = 53;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {5'd0,  8'h12, 8'h34, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
    {5'd1,  8'hA5, 8'h00, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0},
    {5'd2,  8'h00, 8'h3C, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0},
    {5'd3,  8'h01, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0},
    {5'd3,  8'h80, 8'h00, 1'b0, 8'h80, 1'b1, 1'b1, 1'b0},
    {5'd4,  8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {5'd5,  8'h34, 8'h12, 1'b0, 8'hD2, 1'b1, 1'b0, 1'b0},
    {5'd5,  8'hFF, 8'h00, 1'b0, 8'h19, 1'b0, 1'b0, 1'b0},
    {5'd6,  8'h34, 8'h12, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {5'd6,  8'hFF, 8'h00, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0},
    {5'd7,  8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd7,  8'h00, 8'h7F, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0},
    {5'd8,  8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0},
    {5'd8,  8'h00, 8'h80, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b0},
    {5'd9,  8'h7F, 8'h01, 1'b1, 8'h80, 1'b0, 1'b1, 1'b0},
    {5'd9,  8'hFF, 8'h02, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0},
    {5'd10, 8'h05, 8'h07, 1'b1, 8'hFE, 1'b1, 1'b0, 1'b0},
    {5'd10, 8'h05, 8'h07, 1'b0, 8'hFE, 1'b1, 1'b0, 1'b0},
    {5'd10, 8'h80, 8'h01, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b0},
    {5'd11, 8'h03, 8'h10, 1'b1, 8'h0D, 1'b0, 1'b0, 1'b0},
    {5'd12, 8'hFF, 8'h01, 1'b0, 8'hFE, 1'b1, 1'b0, 1'b0},
    {5'd12, 8'h01, 8'hFF, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0},
    {5'd13, 8'h10, 8'h20, 1'b1, 8'h31, 1'b0, 1'b0, 1'b0},
    {5'd13, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd13, 8'h10, 8'h20, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0},
    {5'd14, 8'h10, 8'h05, 1'b1, 8'h0A, 1'b0, 1'b0, 1'b0},
    {5'd14, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0},
    {5'd15, 8'h05, 8'h10, 1'b1, 8'h0A, 1'b0, 1'b0, 1'b0},
    {5'd16, 8'hFF, 8'hFF, 1'b0, 8'hFE, 1'b0, 1'b0, 1'b0},
    {5'd17, 8'hFF, 8'hFF, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0},
    {5'd17, 8'h10, 8'h0F, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b0},
    {5'd18, 8'h64, 8'h07, 1'b0, 8'h0E, 1'b0, 1'b0, 1'b0},
    {5'd19, 8'h64, 8'h07, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
    {5'd18, 8'h64, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1},
    {5'd19, 8'h64, 8'h00, 1'b0, 8'h64, 1'b0, 1'b0, 1'b1},
    {5'd20, 8'h81, 8'h01, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0},
    {5'd20, 8'h81, 8'hF8, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0},
    {5'd20, 8'h01, 8'h07, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0},
    {5'd21, 8'h86, 8'h02, 1'b0, 8'hE1, 1'b1, 1'b0, 1'b0},
    {5'd22, 8'h86, 8'h0A, 1'b0, 8'h21, 1'b1, 1'b0, 1'b0},
    {5'd23, 8'h80, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd23, 8'h01, 8'h02, 1'b1, 8'h06, 1'b0, 1'b0, 1'b0},
    {5'd24, 8'h01, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd24, 8'h00, 8'h03, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0},
    {5'd25, 8'hF0, 8'h3C, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0},
    {5'd26, 8'hF0, 8'h3C, 1'b0, 8'hFC, 1'b0, 1'b0, 1'b0},
    {5'd27, 8'hF0, 8'h3C, 1'b0, 8'hCC, 1'b0, 1'b0, 1'b0},
    {5'd28, 8'hF0, 8'h3C, 1'b0, 8'hCF, 1'b0, 1'b0, 1'b0},
    {5'd29, 8'h00, 8'h3C, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0},
    {5'd30, 8'h45, 8'h38, 1'b1, 8'h83, 1'b0, 1'b0, 1'b0},
    {5'd30, 8'h99, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd31, 8'h45, 8'h38, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0},
    {5'd31, 8'h05, 8'h10, 1'b0, 8'h95, 1'b1, 1'b0, 1'b0}
  };

  function automatic string req_of(logic [4:0] o);
    case (o)
      5'd0, 5'd1, 5'd2:               return "R1";
      5'd5, 5'd6:                     return "R2";
      5'd3, 5'd4, 5'd7, 5'd8:         return "R3";
      5'd9, 5'd10, 5'd11:             return "R4";
      5'd12:                          return "R5";
      5'd13, 5'd14, 5'd15:            return "R6";
      5'd16, 5'd17:                   return "R7";
      5'd18, 5'd19:                   return "R8";
      5'd20, 5'd21, 5'd22:            return "R9";
      5'd23, 5'd24:                   return "R10";
      5'd30, 5'd31:                   return "R12";
      default:                        return "R11";
    endcase
  endfunction

  task automatic apply(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y, input logic ci);
    @(posedge clk);
    op = o; a = x; b = y; cin = ci;
    @(negedge clk);
  endtask

  // {result, carry, ovf, div_err}
  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%b actual=%h expected=%h", req, op, a, b, cin, act, exp);
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // quiet state: code 0 with zero operands
    check("R1", {res, c, v, e}, 11'h000);
    check("R13", {9'd0, z, n}, {9'd0, 1'b1, 1'b0});

    for (int i = 0; i < NV; i++) begin
      logic [32:0] t;
      t = VEC[i];
      apply(t[32:28], t[27:20], t[19:12], t[11]);
      check(req_of(t[32:28]), {res, c, v, e}, t[10:0]);
      check("R13", {9'd0, z, n}, {9'd0, t[10:3] == 8'h00, t[10]});
    end

    // R9 shift-left sweep: expected built by repeated single-bit shifts
    for (int s = 0; s < 8; s++) begin
      logic [7:0] x;
      logic       co;
      x = 8'hB5; co = 1'b0;
      for (int k = 0; k < s; k++) begin co = x[7]; x = {x[6:0], 1'b0}; end
      apply(5'd20, 8'hB5, 8'(s) | 8'h48, 1'b1);
      check("R9", {res, c, v, e}, {x, co, 2'b00});
    end

    // R10 round trip: rotate left then right by the same amount restores ring
    for (int s = 0; s < 8; s++) begin
      logic [7:0] r1;
      logic       c1;
      apply(5'd23, 8'hC6, 8'(s), 1'b1);
      r1 = res; c1 = c;
      apply(5'd24, r1, 8'(s), c1);
      check("R10", {res, c, v, e}, {8'hC6, 1'b1, 2'b00});
    end

    // R8 divide by zero over several dividends; no error on other codes
    for (int k = 0; k < 4; k++) begin
      logic [7:0] x;
      x = 8'(k * 67 + 1);
      apply(5'd18, x, 8'h00, 1'b1);
      check("R8", {res, c, v, e}, {8'hFF, 3'b001});
      apply(5'd19, x, 8'h00, 1'b0);
      check("R8", {res, c, v, e}, {x, 3'b001});
      apply(5'd17, x, 8'h00, 1'b0);
      check("R8", {res, c, v, e}, {8'h00, 3'b000});
    end

    // R12 carry input has no effect on decimal add
    apply(5'd30, 8'h27, 8'h15, 1'b0);
    check("R12", {res, c, v, e}, {8'h42, 3'b000});
    apply(5'd30, 8'h27, 8'h15, 1'b1);
    check("R12", {res, c, v, e}, {8'h42, 3'b000});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule